// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts one 128-bit block with AES-128. A full-width round datapath computes a whole round in one clock cycle. It runs once for the initial key whitening and then once for each of the ten rounds. The 128-bit state is kept in one register. A small sequencer walks it through a whitening phase, nine full rounds and a last round that has no column mixing. Each full round applies byte substitution, row rotation, column mixing and round-key XOR.

The host loads the plaintext as 32-bit words through a word-addressed write port, then pulses a start strobe. The key schedule sits outside the block. The encryptor puts the index of the round key it needs on `rk_idx`, and the schedule returns that 128-bit key on `rk_in` in the same cycle. When the block completes, the ciphertext is read back one word at a time through a read address. The `idle` flag shows that the block can accept a start. The `done` flag shows that the held result is valid.

Top module: `aes128_iter_enc`

## Requirements
- R1: While reset is asserted and right after it, `idle` is 1, `done` is 0, `rk_idx` is 0, and every word read through `rd_addr` is zero.
- R2: A write with `wr_en` high stores `wr_data` as input word `wr_addr`. Word w carries plaintext bytes 4w to 4w+3, with byte 4w in bits 31:24, so word w is state column w. A write touches only the addressed word.
- R3: A `blk_start` pulse sampled while `idle` is 1 starts a block. From the next cycle, `idle` and `done` are both 0 until the block completes.
- R4: Call the clock edge that accepts the start edge 0. After edge k, for k = 0 to 10, `rk_idx` equals k. While busy it never skips or repeats a value, and it never exceeds 10.
- R5: After edge 11, `done` and `idle` are both 1. In the cycle before `done` rises, `rk_idx` is 10.
- R6: The result is the AES-128 ciphertext of the loaded block, given that `rk_in` carries round key i whenever `rk_idx` is i. Bits 127:96 of `rk_in` hold schedule word 4i. Example: plaintext 3243f6a8885a308d313198a2e0370734 under key 2b7e151628aed2a6abf7158809cf4f3c gives 3925841d02dc09fbdc118597196a0b32.
- R7: Byte substitution is the multiplicative inverse modulo x^8+x^4+x^3+x+1 followed by the affine map with constant 0x63, and 0x00 maps to 0x63. This holds for all 256 byte values.
- R8: A `blk_start` pulse while busy is ignored. The running block keeps its index sequence, timing and result, and no second block follows it.
- R9: Word writes made while a block is running do not change that block's result. They form the plaintext of the next start.
- R10: After completion, the ciphertext stays readable and unchanged for any order and number of reads until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Plaintext word write enable |
| wr_addr | input | 2 | Plaintext word index (column) |
| wr_data | input | 32 | Plaintext word |
| blk_start | input | 1 | Start strobe, accepted when idle |
| rd_addr | input | 2 | Ciphertext word index to read |
| rd_data | output | 32 | Ciphertext word selected by rd_addr |
| rk_idx | output | 4 | Index of the round key needed this cycle |
| rk_in | input | 128 | Round key for rk_idx, returned in the same cycle |
| idle | output | 1 | Block can accept a start |
| done | output | 1 | Held ciphertext is valid |

## Verification
The bench builds the block with its default configuration: 32-bit words and ten rounds. At that size the reference cipher and key schedule in the bench are cheap, so every block can be checked cycle by cycle. With an all-zero key, the first round substitutes the plaintext bytes directly. A sweep of 256 blocks, each filled with one repeated byte value, therefore passes every substitution input through the datapath. Pseudo-random keys and plaintexts cover the mixing and row rotation. Mid-flight writes and a start pulse while busy probe how the input buffer is kept apart from the running state.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

   localparam int AES_BLOCK_W = 128;
   localparam int AES_BYTES   = AES_BLOCK_W / 8;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_INIT  = 2'd1,
      PH_ROUND = 2'd2,
      PH_FINAL = 2'd3
   } phase_t;

   // multiply by x in GF(2^8), field polynomial 0x11b
   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] p;
      acc = 8'h00;
      p   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ p;
         p = gf_dbl(p);
      end
      return acc;
   endfunction

   // inverse as a^254 (240 + 12 + 2); zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] a2, a3, a6, a12, a15, a30, a60, a120, a240, a252;
      a2   = gf_mul(a, a);
      a3   = gf_mul(a2, a);
      a6   = gf_mul(a3, a3);
      a12  = gf_mul(a6, a6);
      a15  = gf_mul(a12, a3);
      a30  = gf_mul(a15, a15);
      a60  = gf_mul(a30, a30);
      a120 = gf_mul(a60, a60);
      a240 = gf_mul(a120, a120);
      a252 = gf_mul(a240, a12);
      return gf_mul(a252, a2);
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
      return (x << n) | (x >> (8 - n));
   endfunction

endpackage

// File: rtl/aes_enc_sbox.sv
module aes_enc_sbox
   import aes_enc_pkg::*;
(
   input  logic [7:0] din,
   output logic [7:0] dout
);

   logic [7:0] inv;

   always_comb begin
      inv  = gf_inv(din);
      dout = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
   end

endmodule

// File: rtl/aes_enc_round.sv
module aes_enc_round
   import aes_enc_pkg::*;
(
   input  logic [AES_BLOCK_W-1:0] st,
   input  logic [AES_BLOCK_W-1:0] rk,
   input  logic                   last,
   output logic [AES_BLOCK_W-1:0] nxt
);

   localparam int COLS = AES_BYTES / 4;

   logic [7:0] sb [AES_BYTES];
   logic [7:0] sr [AES_BYTES];
   logic [7:0] mc [AES_BYTES];

   // byte i = 4*column + row, byte 0 in the top bits
   for (genvar i = 0; i < AES_BYTES; i++) begin : g_sub
      aes_enc_sbox u_sbox (
         .din  (st[AES_BLOCK_W-1-8*i -: 8]),
         .dout (sb[i])
      );
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      for (genvar r = 0; r < 4; r++) begin : g_row
         // row r moves left by r columns
         assign sr[4*c+r] = sb[4*((c+r)%COLS)+r];
         // 2*a_r ^ 3*a_{r+1} ^ a_{r+2} ^ a_{r+3}
         assign mc[4*c+r] = gf_dbl(sr[4*c+r])
                          ^ gf_dbl(sr[4*c+(r+1)%4]) ^ sr[4*c+(r+1)%4]
                          ^ sr[4*c+(r+2)%4]
                          ^ sr[4*c+(r+3)%4];
      end
   end

   for (genvar i = 0; i < AES_BYTES; i++) begin : g_key
      assign nxt[AES_BLOCK_W-1-8*i -: 8] = (last ? sr[i] : mc[i]) ^ rk[AES_BLOCK_W-1-8*i -: 8];
   end

endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl
   import aes_enc_pkg::*;
#(
   parameter int NUM_ROUNDS = 10,
   parameter int IDX_W      = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output phase_t           phase,
   output logic [IDX_W-1:0] rnd_idx,
   output logic             idle,
   output logic             done
);

   localparam logic [IDX_W-1:0] LAST_MID = IDX_W'(NUM_ROUNDS - 1);

   phase_t           ph_q;
   logic [IDX_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q   <= PH_INIT;
                  done_q <= 1'b0;
               end
            end
            PH_INIT: begin
               ph_q  <= PH_ROUND;
               cnt_q <= IDX_W'(1);
            end
            PH_ROUND: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_MID) ph_q <= PH_FINAL;
            end
            PH_FINAL: begin
               ph_q   <= PH_IDLE;
               cnt_q  <= '0;
               done_q <= 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign phase   = ph_q;
   assign rnd_idx = cnt_q;
   assign idle    = (ph_q == PH_IDLE);
   assign done    = done_q;

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
   import aes_enc_pkg::*;
#(
   parameter  int WORD_W     = 32,
   parameter  int NUM_ROUNDS = 10,
   localparam int NUM_WORDS  = AES_BLOCK_W / WORD_W,
   localparam int ADDR_W     = $clog2(NUM_WORDS),
   localparam int IDX_W      = $clog2(NUM_ROUNDS + 1)
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [WORD_W-1:0]      wr_data,
   input  logic                   blk_start,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [WORD_W-1:0]      rd_data,
   output logic [IDX_W-1:0]       rk_idx,
   input  logic [AES_BLOCK_W-1:0] rk_in,
   output logic                   idle,
   output logic                   done
);

   if (WORD_W % 8 != 0 || AES_BLOCK_W % WORD_W != 0 || WORD_W > AES_BLOCK_W / 2) begin : g_bad_word
      $error("aes128_iter_enc: WORD_W must be a byte multiple dividing the block into at least two words");
   end
   if (NUM_ROUNDS < 2) begin : g_bad_rounds
      $error("aes128_iter_enc: NUM_ROUNDS must be at least 2");
   end

   phase_t                 phase;
   logic [AES_BLOCK_W-1:0] inbuf_q;
   logic [AES_BLOCK_W-1:0] state_q;
   logic [AES_BLOCK_W-1:0] round_out;
   logic [WORD_W-1:0]      res_word [NUM_WORDS];

   aes_enc_ctrl #(
      .NUM_ROUNDS (NUM_ROUNDS),
      .IDX_W      (IDX_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (blk_start),
      .phase   (phase),
      .rnd_idx (rk_idx),
      .idle    (idle),
      .done    (done)
   );

   // input words are kept apart from the running state
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            inbuf_q[AES_BLOCK_W-1-w*WORD_W -: WORD_W] <= '0;
         end else if (wr_en && wr_addr == ADDR_W'(w)) begin
            inbuf_q[AES_BLOCK_W-1-w*WORD_W -: WORD_W] <= wr_data;
         end
      end
      assign res_word[w] = state_q[AES_BLOCK_W-1-w*WORD_W -: WORD_W];
   end

   aes_enc_round u_round (
      .st   (state_q),
      .rk   (rk_in),
      .last (phase == PH_FINAL),
      .nxt  (round_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else begin
         unique case (phase)
            PH_INIT:           state_q <= inbuf_q ^ rk_in;
            PH_ROUND, PH_FINAL: state_q <= round_out;
            default:           state_q <= state_q;
         endcase
      end
   end

   assign rd_data = res_word[rd_addr];

endmodule

// File: rtl/aes_enc_chk.sv
module aes_enc_chk #(
   parameter int NUM_ROUNDS = 10,
   parameter int IDX_W      = 4,
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              blk_start,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [WORD_W-1:0] rd_data,
   input logic [IDX_W-1:0]  rk_idx,
   input logic              idle,
   input logic              done
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS);

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rk_idx <= LAST_IDX); // R4

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && rk_idx != '0) |-> rk_idx == $past(rk_idx) + 1'b1); // R4

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && blk_start) |=> (!idle && !done && rk_idx == '0)); // R3

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> idle); // R5

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(rk_idx) == LAST_IDX); // R5

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && blk_start && rk_idx != LAST_IDX) |=> !idle); // R8

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done) && $stable(rd_addr)) |-> $stable(rd_data)); // R10

endmodule

bind aes128_iter_enc aes_enc_chk #(
   .NUM_ROUNDS (NUM_ROUNDS),
   .IDX_W      (IDX_W),
   .WORD_W     (WORD_W),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .blk_start (blk_start),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data),
   .rk_idx    (rk_idx),
   .idle      (idle),
   .done      (done)
);

// File: tb/aes128_iter_enc_tb.sv
module aes128_iter_enc_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic         blk_start = 1'b0;
   logic [1:0]   rd_addr = '0;
   logic [31:0]  rd_data;
   logic [3:0]   rk_idx;
   logic [127:0] rk_in;
   logic         idle;
   logic         done;

   logic [127:0] ks [11];
   logic [7:0]   sb_t [256];
   int           n_run = 0;
   int           n_fail = 0;
   bit           all_done = 1'b0;
   int unsigned  lcg = 32'h1234_5678;

   always #5 clk = ~clk;

   aes128_iter_enc u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .blk_start (blk_start),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rk_idx    (rk_idx),
      .rk_in     (rk_in),
      .idle      (idle),
      .done      (done)
   );

   // external key schedule: answers the requested index in the same cycle
   always_comb rk_in = (rk_idx <= 4'd10) ? ks[rk_idx] : '0;

   // ---------------- reference arithmetic ----------------
   function automatic logic [7:0] mul_ref(input logic [7:0] a, input logic [7:0] b);
      logic [14:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
      for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11b << (k - 8));
      return p[7:0];
   endfunction

   task automatic build_sbox();
      for (int x = 0; x < 256; x++) begin
         logic [7:0] inv, v;
         inv = 8'h00;
         for (int y = 1; y < 256; y++) if (mul_ref(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
         for (int i = 0; i < 8; i++)
            v[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i;
         sb_t[x] = v;
      end
   endtask

   task automatic expand(input logic [127:0] key);
      logic [31:0] w [44];
      logic [31:0] t;
      logic [7:0]  rc;
      rc = 8'h01;
      for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         t = w[i-1];
         if (i % 4 == 0) begin
            t = {t[23:0], t[31:24]};
            t = {sb_t[t[31:24]], sb_t[t[23:16]], sb_t[t[15:8]], sb_t[t[7:0]]} ^ {rc, 24'h0};
            rc = mul_ref(rc, 8'h02);
         end
         w[i] = w[i-4] ^ t;
      end
      for (int r = 0; r < 11; r++) ks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
   endtask

   function automatic logic [127:0] ref_enc(input logic [127:0] pt);
      logic [7:0]   s [16];
      logic [7:0]   t [16];
      logic [7:0]   a [4];
      logic [127:0] out;
      for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ ks[0][127-8*i -: 8];
      for (int r = 1; r <= 10; r++) begin
         for (int i = 0; i < 16; i++) t[i] = sb_t[s[i]];
         for (int c = 0; c < 4; c++)
            for (int w = 0; w < 4; w++) s[w+4*c] = t[w+4*((c+w)%4)];
         if (r < 10) begin
            for (int c = 0; c < 4; c++) begin
               for (int j = 0; j < 4; j++) a[j] = s[4*c+j];
               s[4*c+0] = mul_ref(8'h02, a[0]) ^ mul_ref(8'h03, a[1]) ^ a[2] ^ a[3];
               s[4*c+1] = a[0] ^ mul_ref(8'h02, a[1]) ^ mul_ref(8'h03, a[2]) ^ a[3];
               s[4*c+2] = a[0] ^ a[1] ^ mul_ref(8'h02, a[2]) ^ mul_ref(8'h03, a[3]);
               s[4*c+3] = mul_ref(8'h03, a[0]) ^ a[1] ^ a[2] ^ mul_ref(8'h02, a[3]);
            end
         end
         for (int i = 0; i < 16; i++) s[i] = s[i] ^ ks[r][127-8*i -: 8];
      end
      for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
      return out;
   endfunction

   // ---------------- bench helpers ----------------
   task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rnd128(output logic [127:0] v);
      for (int i = 0; i < 4; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         v[127-32*i -: 32] = lcg;
      end
   endtask

   task automatic write_word(input int w, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(w); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_pt(input logic [127:0] pt);
      for (int w = 0; w < 4; w++) write_word(w, pt[127-32*w -: 32]);
   endtask

   task automatic read_ct(output logic [127:0] ct, input bit reverse);
      for (int j = 0; j < 4; j++) begin
         int w;
         w = reverse ? 3 - j : j;
         @(negedge clk);
         rd_addr = 2'(w);
         #1;
         ct[127-32*w -: 32] = rd_data;
      end
   endtask

   // start, follow every cycle, read back; optional mid-flight writes and start poke
   task automatic run_blk(input string req, input logic [127:0] exp,
                          input bit mid_en, input logic [127:0] mid_pt, input bit poke);
      logic [127:0] ct;
      @(negedge clk);
      blk_start = 1'b1;
      @(negedge clk);
      blk_start = 1'b0;
      chk("R3", "done cleared after start", 128'(done), 128'(0));
      for (int k = 0; k <= 10; k++) begin
         chk("R4", "round key index", 128'(rk_idx), 128'(k));
         chk("R3", "idle low while busy", 128'(idle), 128'(0));
         wr_en = mid_en && k >= 2 && k <= 5;
         if (wr_en) begin
            wr_addr = 2'(k - 2);
            wr_data = mid_pt[127-32*(k-2) -: 32];
         end
         blk_start = poke && (k == 7);
         @(negedge clk);
      end
      wr_en = 1'b0;
      blk_start = 1'b0;
      chk("R5", "done after last round", 128'(done), 128'(1));
      chk("R5", "idle after last round", 128'(idle), 128'(1));
      read_ct(ct, 1'b0);
      chk(req, "ciphertext", ct, exp);
   endtask

   // ---------------- sequence ----------------
   initial begin
      logic [127:0] pt, key, pt2, ct_a, ct_b, exp;
      build_sbox();
      for (int r = 0; r < 11; r++) ks[r] = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "idle in reset", 128'(idle), 128'(1));
      chk("R1", "done in reset", 128'(done), 128'(0));
      chk("R1", "index in reset", 128'(rk_idx), 128'(0));
      for (int w = 0; w < 4; w++) begin
         rd_addr = 2'(w);
         #1;
         chk("R1", "result word in reset", 128'(rd_data), 128'(0));
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", 128'(idle), 128'(1));
      chk("R1", "done after reset", 128'(done), 128'(0));

      // R6 / R2: known-answer vector
      key = 128'h2b7e151628aed2a6abf7158809cf4f3c;
      pt  = 128'h3243f6a8885a308d313198a2e0370734;
      expand(key);
      chk("R6", "reference model vs known answer", ref_enc(pt), 128'h3925841d02dc09fbdc118597196a0b32);
      load_pt(pt);
      run_blk("R6", 128'h3925841d02dc09fbdc118597196a0b32, 1'b0, '0, 1'b0);

      // R10: held result, reverse read order after a wait
      repeat (20) @(negedge clk);
      read_ct(ct_a, 1'b1);
      chk("R10", "result held", ct_a, 128'h3925841d02dc09fbdc118597196a0b32);
      chk("R10", "done still set", 128'(done), 128'(1));

      // R2: rewrite only column 2, rerun
      pt2 = pt;
      pt2[63:32] = 32'hdeadbeef;
      write_word(2, 32'hdeadbeef);
      run_blk("R2", ref_enc(pt2), 1'b0, '0, 1'b0);

      // R8 / R9: mid-flight writes of block B and a busy start during block A
      rnd128(key);
      expand(key);
      rnd128(pt);
      rnd128(pt2);
      load_pt(pt);
      run_blk("R9", ref_enc(pt), 1'b1, pt2, 1'b1);
      chk("R8", "no second block after busy start", 128'(idle), 128'(1));
      chk("R8", "done kept after busy start", 128'(done), 128'(1));
      run_blk("R9", ref_enc(pt2), 1'b0, '0, 1'b0);

      // R6: pseudo-random keys and plaintexts
      for (int n = 0; n < 24; n++) begin
         rnd128(key);
         rnd128(pt);
         expand(key);
         load_pt(pt);
         run_blk("R6", ref_enc(pt), 1'b0, '0, 1'b0);
      end

      // R7: zero key, every byte value through the first substitution
      expand('0);
      for (int b = 0; b < 256; b++) begin
         pt = {16{8'(b)}};
         exp = ref_enc(pt);
         load_pt(pt);
         run_blk("R7", exp, 1'b0, '0, 1'b0);
      end
      chk("R7", "zero maps to 0x63", 128'(sb_t[0]), 128'(8'h63));

      read_ct(ct_b, 1'b1);
      chk("R10", "final result held", ct_b, ref_enc({16{8'hff}}));

      all_done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!all_done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual still running expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule